// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synthesizable behavioural model of a single-clock synchronous static RAM. The word is 36 bits wide and is split into four 9-bit byte lanes. An access starts when either of two address strobes is asserted. A processor-side strobe is qualified by the first chip enable, and a controller-side strobe is unqualified. Starting an access loads the external address. Later cycles can step through the rest of a four-word burst with an advance input. An internal 2-bit counter generates these addresses in linear or interleaved order. Bursting is optional: a fresh address may be presented on every clock.

Two pins select the operating mode. The first picks the burst order. The second picks the read latency: flow-through, where the word appears after the sampling edge, or pipelined, where it appears one edge later. Writes are done per lane through a byte-write enable and four lane selects. A global write stores the whole word. The output-enable and sleep inputs act without waiting for the clock and gate the read bus. Sleep also blocks every access without disturbing the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: An access starts when `ctl_strobe_n` is low, or when `cpu_strobe_n` is low while `cs1_n` is low, and it loads `addr` as the burst start. With `cs1_n` high the processor strobe counts as no strobe: a burst already running holds its current address and keeps returning the same word.
- R2: The chip is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A strobe cycle while unselected is a deselect: nothing is written, no data is returned and the running burst ends.
- R3: With `linear_order`=1, each cycle that has no strobe and `adv_n` low steps a 2-bit count n, and the address becomes the start address with its two low bits replaced by (start_low + n) mod 4. The upper bits stay unchanged. A cycle with no strobe and `adv_n` high repeats the current address.
- R4: With `linear_order`=0 (interleaved), the low two address bits during a burst are start_low XOR n.
- R5: A new address can be loaded on every clock, and back-to-back single reads return one word per cycle.
- R6: With `pipe_mode`=0, the read word of a command sampled at edge k is on `dout` after edge k. With `pipe_mode`=1 it appears after edge k+1 and not after edge k.
- R7: When `all_wr_n` is high, lane i (bits 9i+8 down to 9i) is written only if `lane_wr_n`=0 and `lane_sel_n[i]`=0. The other lanes keep their contents. With `lane_wr_n` high nothing is written.
- R8: With `all_wr_n`=0 all four lanes are written, whatever `lane_wr_n` and `lane_sel_n` are. A write cycle returns no read data.
- R9: A cycle started by the processor strobe is always a read. Write controls in that cycle are ignored.
- R10: After a deselect edge, `dout_drive` falls at once in flow-through mode. In pipelined mode it stays high for one more cycle with the last word, then falls.
- R11: `oe_n` high forces `dout_drive` low without waiting for a clock. Whenever `dout_drive` is low, `dout` is zero.
- R12: `sleep` high forces `dout_drive` low at once. At edges where `sleep` is high no read or write happens, and the memory keeps its contents.
- R13: During and right after reset, `dout_drive` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled with a strobe |
| cs1_n | input | 1 | Chip select 1, active low, also qualifies the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| linear_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| pipe_mode | input | 1 | Read latency: 1 pipelined, 0 flow-through |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_drive | output | 1 | High while `dout` carries read data |

## Verification
The properties treat `pipe_mode` and `linear_order` as static straps. The deselect and write checks accept a latency-mode change that lands in the following cycle. They also assume that every input settles well away from the rising edge. The stimulus meets both conditions. All inputs are driven on the falling edge. The two mode pins are changed only after a deselect, followed by an idle cycle in which no burst is active. `oe_n` and `sleep` are toggled in mid-cycle only to observe their asynchronous effect, and they return to their quiet value before the next command.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the synchronous burst RAM.
// Assumes a 2-bit burst count, so each burst spans four words.
package sbs_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_DESEL = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STEP  = 3'd3,
        OP_HOLD  = 3'd4
    } sbs_op_e;

    // Low two address bits for burst position cnt starting at base.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       linear);
        logic [1:0] sum;
        sum = base + cnt;
        return linear ? sum : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
// Command decoder and burst address generator.
// It classifies each sampled cycle (load, step, hold, deselect or idle) and
// produces the access address, write flag and lane mask for the array.
// It assumes the mode pins are static while a burst is running.
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              adv_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              linear_order,
    output logic              acc_en,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask
);

    logic              selected;
    logic              cpu_go;
    logic              strobe;
    logic              wr_req;
    sbs_op_e           op;
    logic              active_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_use;

    // Decode chip select and the two strobes.
    always_comb begin
        selected = !cs1_n && cs2 && !cs3_n;
        cpu_go   = !cpu_strobe_n && !cs1_n;
        strobe   = cpu_go || !ctl_strobe_n;
    end

    // Classify the cycle; sleep suppresses every operation.
    always_comb begin
        if (sleep)             op = OP_NONE;
        else if (strobe)       op = selected ? OP_LOAD : OP_DESEL;
        else if (active_q)     op = adv_n ? OP_HOLD : OP_STEP;
        else                   op = OP_NONE;
    end

    // Form the access address from the external bus or the burst counter.
    always_comb begin
        cnt_use  = (op == OP_STEP) ? cnt_q + 2'd1 : cnt_q;
        acc_addr = (op == OP_LOAD) ? addr
                 : {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_use, linear_order)};
    end

    // Write request and lane mask; a processor-strobe start is read only.
    always_comb begin
        wr_req   = !all_wr_n || (!lane_wr_n && (lane_sel_n != '1));
        acc_mask = !all_wr_n ? '1 : (!lane_wr_n ? ~lane_sel_n : '0);
        acc_en   = (op == OP_LOAD) || (op == OP_STEP) || (op == OP_HOLD);
        acc_wr   = acc_en && wr_req && !((op == OP_LOAD) && cpu_go);
    end

    // Burst state: start address, position count and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            case (op)
                OP_LOAD: begin
                    active_q <= 1'b1;
                    base_q   <= addr;
                    cnt_q    <= '0;
                end
                OP_STEP:  cnt_q    <= cnt_q + 2'd1;
                OP_DESEL: active_q <= 1'b0;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
// Storage array, one memory per byte lane, with a registered read port.
// A write stores the masked lanes at the access address. A read captures
// the word into the read register at the same edge. Contents are not reset.
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     acc_en,
    input  logic                     acc_wr,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [LANES-1:0]         acc_mask,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Per-lane write and registered read.
        always_ff @(posedge clk) begin
            if (acc_en && acc_wr && acc_mask[g])
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            if (acc_en && !acc_wr)
                rd_q <= mem[acc_addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/sbs_outstage.sv
`timescale 1ns/1ps
// Read output stage. It tracks which array reads are valid, adds the
// optional pipeline register and gates the bus with the output enable
// and sleep inputs, which act without waiting for the clock.
module sbs_outstage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic              pipe_mode,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);

    logic              v1_q;
    logic              v2_q;
    logic [DATA_W-1:0] d2_q;
    logic              stage_ok;

    // Valid flags for the array read register and the pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= rd_fire;
            v2_q <= v1_q && !sleep;
        end
    end

    // Pipeline data register.
    always_ff @(posedge clk) begin
        if (v1_q) d2_q <= rd_word;
    end

    // Select the latency path and gate the bus.
    always_comb begin
        stage_ok   = pipe_mode ? v2_q : v1_q;
        dout_drive = stage_ok && !oe_n && !sleep;
        dout       = dout_drive ? (pipe_mode ? d2_q : rd_word) : '0;
    end

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
// Synchronous burst static RAM top level. It wires the command decoder,
// the lane-split array and the output stage together. Synchronous inputs
// are sampled on the rising clock edge. Mode pins are treated as straps.
module sync_burst_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     cs3_n,
    input  logic                     cpu_strobe_n,
    input  logic                     ctl_strobe_n,
    input  logic                     adv_n,
    input  logic                     all_wr_n,
    input  logic                     lane_wr_n,
    input  logic [LANES-1:0]         lane_sel_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic                     oe_n,
    input  logic                     sleep,
    input  logic                     linear_order,
    input  logic                     pipe_mode,
    output logic [LANES*LANE_W-1:0]  dout,
    output logic                     dout_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic              acc_en;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_mask;
    logic [DATA_W-1:0] rd_word;

    sbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep        (sleep),
        .addr         (addr),
        .cs1_n        (cs1_n),
        .cs2          (cs2),
        .cs3_n        (cs3_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .adv_n        (adv_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_n    (lane_wr_n),
        .lane_sel_n   (lane_sel_n),
        .linear_order (linear_order),
        .acc_en       (acc_en),
        .acc_wr       (acc_wr),
        .acc_addr     (acc_addr),
        .acc_mask     (acc_mask)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .acc_mask (acc_mask),
        .wdata    (wdata),
        .rdata    (rd_word)
    );

    sbs_outstage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .oe_n       (oe_n),
        .pipe_mode  (pipe_mode),
        .rd_fire    (acc_en && !acc_wr),
        .rd_word    (rd_word),
        .dout       (dout),
        .dout_drive (dout_drive)
    );

endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
// Port-level properties of the burst RAM. It assumes the mode pins change
// only while idle and that inputs settle away from the rising edge.
module sbs_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              all_wr_n,
    input logic              sleep,
    input logic              oe_n,
    input logic              pipe_mode,
    input logic [DATA_W-1:0] dout,
    input logic              dout_drive
);

    logic chk_sel;
    logic chk_strobe;

    // Independent decode of selection and strobe from the pins.
    always_comb begin
        chk_sel    = !cs1_n && cs2 && !cs3_n;
        chk_strobe = (!cpu_strobe_n && !cs1_n) || !ctl_strobe_n;
    end

    AST_OE_BLOCKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_drive);                                              // R11
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_drive |-> (dout == '0));                                      // R11
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_drive);                                             // R12
    AST_FLOW_DESELECT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !pipe_mode && chk_strobe && !chk_sel)
        |=> (pipe_mode || !dout_drive));                                    // R10
    AST_FLOW_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !pipe_mode && !ctl_strobe_n && chk_sel && !all_wr_n)
        |=> (pipe_mode || !dout_drive));                                    // R8

endmodule

bind sync_burst_sram sbs_checker #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs1_n        (cs1_n),
    .cs2          (cs2),
    .cs3_n        (cs3_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .all_wr_n     (all_wr_n),
    .sleep        (sleep),
    .oe_n         (oe_n),
    .pipe_mode    (pipe_mode),
    .dout         (dout),
    .dout_drive   (dout_drive)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, with a bench-side word array as reference.
module sync_burst_sram_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        cs1_n, cs2, cs3_n;
    logic        cpu_strobe_n, ctl_strobe_n, adv_n;
    logic        all_wr_n, lane_wr_n;
    logic [3:0]  lane_sel_n;
    logic [35:0] wdata;
    logic        oe_n, sleep, linear_order, pipe_mode;
    logic [35:0] dout;
    logic        dout_drive;

    logic [35:0] ref_mem [256];
    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sync_burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .linear_order(linear_order),
        .pipe_mode(pipe_mode), .dout(dout), .dout_drive(dout_drive)
    );

    task automatic chk(input string tag, input logic exp_drv, input logic [35:0] exp_d);
        n_chk++;
        if (dout_drive !== exp_drv || (exp_drv && dout !== exp_d) || (!exp_drv && dout !== '0)) begin
            n_fail++;
            $display("FAIL %s: drive=%0b exp %0b, dout=%h exp %h", tag, dout_drive, exp_drv,
                     dout, exp_drv ? exp_d : 36'h0);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cmd(input logic [7:0] a, input logic c1n, input logic c2,
                           input logic c3n, input logic cpun, input logic ctln,
                           input logic advn, input logic gwn, input logic bwn,
                           input logic [3:0] seln, input logic [35:0] wd);
        addr = a; cs1_n = c1n; cs2 = c2; cs3_n = c3n;
        cpu_strobe_n = cpun; ctl_strobe_n = ctln; adv_n = advn;
        all_wr_n = gwn; lane_wr_n = bwn; lane_sel_n = seln; wdata = wd;
    endtask

    task automatic ref_write(input logic [7:0] a, input logic gwn, input logic bwn,
                             input logic [3:0] seln, input logic [35:0] wd);
        for (int l = 0; l < 4; l++)
            if (!gwn || (!bwn && !seln[l]))
                ref_mem[a][l*9 +: 9] = wd[l*9 +: 9];
    endtask

    task automatic ctl_cmd(input logic [7:0] a, input logic gwn, input logic bwn,
                           input logic [3:0] seln, input logic [35:0] wd);
        set_cmd(a, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, gwn, bwn, seln, wd);
        tick();
    endtask

    task automatic cpu_cmd(input logic [7:0] a, input logic c1n, input logic gwn,
                           input logic [35:0] wd);
        set_cmd(a, c1n, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, gwn, 1'b1, 4'hF, wd);
        tick();
    endtask

    task automatic adv_cmd(input logic bwn, input logic [3:0] seln, input logic [35:0] wd);
        set_cmd(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, bwn, seln, wd);
        tick();
    endtask

    task automatic desel_cmd();
        set_cmd(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, '0);
        tick();
    endtask

    task automatic nop_cmd();
        set_cmd(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0);
        tick();
    endtask

    task automatic rd(input logic [7:0] a);
        ctl_cmd(a, 1'b1, 1'b1, 4'hF, '0);
    endtask

    function automatic logic [7:0] bexp(input logic [7:0] sa, input int n, input bit lin);
        logic [1:0] nn;
        logic [1:0] s;
        nn = 2'(n);
        s  = sa[1:0] + nn;
        return {sa[7:2], lin ? s : (sa[1:0] ^ nn)};
    endfunction

    task automatic t_reset();
        chk("R13 in reset", 1'b0, '0);
        @(negedge clk); rst_n = 1'b1;
        nop_cmd();
        chk("R13 after reset", 1'b0, '0);
    endtask

    task automatic t_fill_and_stream();
        pipe_mode = 1'b0; linear_order = 1'b1;
        for (int i = 0; i < 16; i++) begin
            logic [35:0] pat;
            pat = 36'h9_8765_4321 ^ 36'(i * 36'h0_0F1E_2D3C);
            ctl_cmd(8'(8'h40 + i), 1'b0, 1'b1, 4'hF, pat);
            ref_write(8'(8'h40 + i), 1'b0, 1'b1, 4'hF, pat);
            chk("R8 write returns no data", 1'b0, '0);
        end
        desel_cmd();
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h40 + i));
            chk("R5 flow back-to-back", 1'b1, ref_mem[8'h40 + i]);
        end
        desel_cmd();
        pipe_mode = 1'b1;
        nop_cmd();
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h48 + i));
            if (i == 0) chk("R6 pipelined not after first edge", 1'b0, '0);
            else        chk("R5 pipelined back-to-back", 1'b1, ref_mem[8'h48 + i - 1]);
        end
        desel_cmd();
        chk("R6 pipelined last word", 1'b1, ref_mem[8'h4F]);
        nop_cmd();
        chk("R10 pipelined stops after one cycle", 1'b0, '0);
    endtask

    task automatic t_burst(input bit lin, input bit pipe, input bit cpu, input logic [7:0] sa);
        string tag;
        tag = lin ? "R3 linear burst" : "R4 interleaved burst";
        linear_order = lin; pipe_mode = pipe;
        nop_cmd();
        for (int b = 0; b < 5; b++) begin
            if (b == 0) begin
                if (cpu) cpu_cmd(sa, 1'b0, 1'b1, '0);
                else     rd(sa);
            end else if (b < 4) adv_cmd(1'b1, 4'hF, '0);
            else desel_cmd();
            if (!pipe) begin
                if (b < 4) chk(tag, 1'b1, ref_mem[bexp(sa, b, lin)]);
                else       chk("R10 flow deselect stops at once", 1'b0, '0);
            end else begin
                if (b == 0) chk("R6 pipelined latency", 1'b0, '0);
                else        chk(tag, 1'b1, ref_mem[bexp(sa, b - 1, lin)]);
            end
        end
        if (pipe) begin
            nop_cmd();
            chk("R10 pipelined deselect", 1'b0, '0);
        end
    endtask

    task automatic t_lane_writes();
        logic [35:0] wd [4];
        logic [3:0]  sl [4];
        wd[0] = 36'hA_AAAA_AAAA; wd[1] = 36'h5_5555_5555;
        wd[2] = 36'h1_2345_6789; wd[3] = 36'hF_EDCB_A987;
        sl[0] = 4'b1010; sl[1] = 4'b0101; sl[2] = 4'b0111; sl[3] = 4'b1110;
        pipe_mode = 1'b0; linear_order = 1'b1;
        nop_cmd();
        ctl_cmd(8'h45, 1'b1, 1'b0, sl[0], wd[0]);
        ref_write(8'h45, 1'b1, 1'b0, sl[0], wd[0]);
        for (int b = 1; b < 4; b++) begin
            adv_cmd(1'b0, sl[b], wd[b]);
            ref_write(bexp(8'h45, b, 1'b1), 1'b1, 1'b0, sl[b], wd[b]);
        end
        desel_cmd();
        for (int b = 0; b < 4; b++) begin
            rd(8'(8'h44 + b));
            chk("R7 lane write merge", 1'b1, ref_mem[8'h44 + b]);
        end
        ctl_cmd(8'h48, 1'b1, 1'b1, 4'h0, 36'h0_DEAD_BEEF);
        rd(8'h48);
        chk("R7 lane selects without byte-write enable", 1'b1, ref_mem[8'h48]);
        ctl_cmd(8'h49, 1'b0, 1'b1, 4'hF, 36'h3_C3C3_C3C3);
        ref_write(8'h49, 1'b0, 1'b1, 4'hF, 36'h3_C3C3_C3C3);
        rd(8'h49);
        chk("R8 global write overrides lane controls", 1'b1, ref_mem[8'h49]);
        desel_cmd();
    endtask

    task automatic t_select();
        pipe_mode = 1'b0;
        set_cmd(8'h4A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 36'h0_BAD0_BAD0);
        tick();
        chk("R2 cs3_n high deselects", 1'b0, '0);
        set_cmd(8'h4A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, '0);
        tick();
        chk("R2 cs2 low deselects", 1'b0, '0);
        rd(8'h4A);
        chk("R2 unselected write ignored", 1'b1, ref_mem[8'h4A]);
        cpu_cmd(8'h4C, 1'b1, 1'b1, '0);
        chk("R1 processor strobe ignored with cs1_n high", 1'b1, ref_mem[8'h4A]);
        desel_cmd();
        cpu_cmd(8'h4E, 1'b0, 1'b0, 36'h7_7777_7777);
        chk("R9 processor start reads", 1'b1, ref_mem[8'h4E]);
        desel_cmd();
        rd(8'h4E);
        chk("R9 processor start did not write", 1'b1, ref_mem[8'h4E]);
        desel_cmd();
    endtask

    task automatic t_oe_sleep();
        pipe_mode = 1'b0;
        rd(8'h42);
        nop_cmd();
        chk("R3 hold repeats address", 1'b1, ref_mem[8'h42]);
        oe_n = 1'b1; #1;
        chk("R11 oe_n high blocks bus", 1'b0, '0);
        oe_n = 1'b0; #1;
        chk("R11 oe_n low restores bus", 1'b1, ref_mem[8'h42]);
        @(negedge clk);
        rd(8'h43);
        sleep = 1'b1; #1;
        chk("R12 sleep blocks bus at once", 1'b0, '0);
        @(negedge clk);
        ctl_cmd(8'h43, 1'b0, 1'b1, 4'hF, 36'h0_0000_1111);
        chk("R12 sleep keeps bus quiet", 1'b0, '0);
        sleep = 1'b0;
        desel_cmd();
        rd(8'h43);
        chk("R12 write during sleep ignored", 1'b1, ref_mem[8'h43]);
        desel_cmd();
    endtask

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        linear_order = 1'b0; pipe_mode = 1'b1;
        set_cmd(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0);
        repeat (3) @(negedge clk);
        t_reset();
        t_fill_and_stream();
        t_burst(1'b1, 1'b0, 1'b0, 8'h41);
        t_burst(1'b1, 1'b1, 1'b1, 8'h46);
        t_burst(1'b0, 1'b0, 1'b1, 8'h4B);
        t_burst(1'b0, 1'b1, 1'b0, 8'h4D);
        t_burst(1'b0, 1'b0, 1'b0, 8'h43);
        t_burst(1'b1, 1'b0, 1'b0, 8'h4F);
        t_lane_writes();
        t_select();
        t_oe_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule